// File: doc/BRIEF.md
# Ordered Arm-and-Fire Trigger Sequencer

This block gates a downstream start event behind a chain of arming steps. It has one go input bit per step. Each bit arms the sequencer in turn, and only the bit belonging to the last step fires it. When the chain completes, the block emits a single-cycle fire pulse and drops back to idle, ready for the next sequence.

The current step is reported on a one-hot status vector that is as wide as the go vector. Its top bit means idle, and its bottom bit means armed and waiting for the final go bit. A go bit that does not belong to the current step has no effect. Out-of-order or premature inputs therefore never advance or fire the sequencer. The number of steps is a parameter and defaults to one. In that case a single go pulse fires on the next clock.

Top module: `trig_arm_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, trigstate_o is idle and gn_o is 0. Idle means only bit NUM_STAGES-1 is set. The reset is asynchronous and active low.
- R2: trigstate_o always has exactly one bit set. Step k (0 = idle, NUM_STAGES-1 = final arm) is shown as bit NUM_STAGES-1-k.
- R3: In step k with k < NUM_STAGES-1, a clock edge that samples go_i[k] high moves the sequencer to step k+1. After that edge, the set bit of trigstate_o has moved one position toward bit 0.
- R4: In step k, a clock edge that samples go_i[k] low leaves the step unchanged and gn_o low, whatever the other go_i bits are.
- R5: In the final arm step, an edge that samples go_i[NUM_STAGES-1] high drives gn_o high for the following cycle, and trigstate_o returns to idle in that same cycle.
- R6: gn_o is high only in a cycle in which trigstate_o shows idle. When NUM_STAGES > 1, gn_o is never high for two consecutive cycles.
- R7: With NUM_STAGES = 1, go_i high in idle gives gn_o high on the next cycle. Holding go_i high gives gn_o high on every following cycle, and trigstate_o stays 1.
- R8: go_i and trigstate_o are both NUM_STAGES bits wide, and NUM_STAGES defaults to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | NUM_STAGES | Per-step arm request; bit k serves step k |
| gn_o | output | 1 | Single-cycle fire pulse |
| trigstate_o | output | NUM_STAGES | One-hot step indicator, MSB = idle, LSB = final arm |

## Verification
A three-step instance is driven through several patterns, each checked against a model that tracks the step count:
- A clean ordered sequence with gaps between the bits shows that arming holds while go is quiet.
- Out-of-order bits, such as the last or middle bit while idle, must be rejected.
- Holding all bits high shows that the sequencer advances one step per clock and fires only after the last step.
- Partial arming followed by wrong bits shows that a step is not lost or skipped.
- A reset in the middle of a sequence shows that arming is abandoned.

A one-step instance runs single pulses and a held go. This separates the degenerate fire-every-cycle case from the multi-step rule that gn_o never repeats.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADV  = 2'd1,
    STEP_FIRE = 2'd2
  } step_e;

endpackage

// File: rtl/trig_step_sel.sv
module trig_step_sel
  import trig_seq_pkg::*;
#(
  parameter int NUM_STAGES = 1
) (
  input  logic [NUM_STAGES-1:0] state_i,
  input  logic [NUM_STAGES-1:0] go_i,
  output step_e                 action_o
);

  // go bit k serves step k, shown at state bit NUM_STAGES-1-k
  logic [NUM_STAGES-1:0] go_rev;
  logic                  hit;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_rev
    assign go_rev[NUM_STAGES-1-i] = go_i[i];
  end

  assign hit = |(state_i & go_rev);

  always_comb begin
    action_o = STEP_HOLD;
    if (hit) action_o = state_i[0] ? STEP_FIRE : STEP_ADV;
  end

endmodule

// File: rtl/trig_state_reg.sv
module trig_state_reg
  import trig_seq_pkg::*;
#(
  parameter int NUM_STAGES = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  step_e                 action_i,
  output logic [NUM_STAGES-1:0] state_o
);

  localparam logic [NUM_STAGES-1:0] IdleVec = (NUM_STAGES)'(1) << (NUM_STAGES-1);

  logic [NUM_STAGES-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IdleVec;
    end else begin
      unique case (action_i)
        STEP_ADV:  state_q <= state_q >> 1;
        STEP_FIRE: state_q <= IdleVec;
        default:   state_q <= state_q;
      endcase
    end
  end

  assign state_o = state_q;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_i == STEP_HOLD |=> $stable(state_q));

  p_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_i == STEP_ADV |=> $countones(state_q) == 1 && !$past(state_q[0]) && state_q != $past(state_q));

  p_fire_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_i == STEP_FIRE |=> state_q[NUM_STAGES-1]);

endmodule

// File: rtl/trig_fire_reg.sv
module trig_fire_reg
  import trig_seq_pkg::*;
#(
  parameter int NUM_STAGES = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_e action_i,
  output logic  gn_o
);

  logic gn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gn_q <= 1'b0;
    else         gn_q <= (action_i == STEP_FIRE);
  end

  assign gn_o = gn_q;

  if (NUM_STAGES > 1) begin : g_multi_chk
    p_gn_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gn_q |=> !gn_q);
  end

endmodule

// File: rtl/trig_arm_seq.sv
module trig_arm_seq
  import trig_seq_pkg::*;
#(
  parameter int NUM_STAGES = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] go_i,
  output logic                  gn_o,
  output logic [NUM_STAGES-1:0] trigstate_o
);

  step_e                 action;
  logic [NUM_STAGES-1:0] state;

  trig_step_sel #(.NUM_STAGES(NUM_STAGES)) u_sel (
    .state_i  (state),
    .go_i     (go_i),
    .action_o (action)
  );

  trig_state_reg #(.NUM_STAGES(NUM_STAGES)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .action_i (action),
    .state_o  (state)
  );

  trig_fire_reg #(.NUM_STAGES(NUM_STAGES)) u_fire (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .action_i (action),
    .gn_o     (gn_o)
  );

  assign trigstate_o = state;

  p_fire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigstate_o[0] && go_i[NUM_STAGES-1] |=> gn_o);

  p_gn_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gn_o |-> trigstate_o[NUM_STAGES-1]);

  p_no_early_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trigstate_o[0] && go_i[NUM_STAGES-1]) |=> !gn_o);

endmodule

// File: tb/trig_arm_seq_tb.sv
`timescale 1ns/1ps
module trig_arm_seq_tb;

  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] go3 = '0;
  logic          go1 = 1'b0;
  logic          gn3, gn1;
  logic [NS-1:0] ts3;
  logic          ts1;

  int errors = 0;
  int checks = 0;
  int stg = 0;      // model step for 3-step instance
  bit exp_gn3 = 0;
  bit exp_gn1 = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trig_arm_seq #(.NUM_STAGES(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go3), .gn_o(gn3), .trigstate_o(ts3)
  );

  trig_arm_seq u_dut_single (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go1), .gn_o(gn1), .trigstate_o(ts1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, advance model, compare after edge
  task automatic cyc(input logic [NS-1:0] g, input logic g1);
    string tag;
    go3 = g;
    go1 = g1;
    exp_gn3 = 0;
    if (g[stg]) begin
      if (stg == NS-1) begin stg = 0; exp_gn3 = 1; tag = "R5"; end
      else begin stg++; tag = "R3"; end
    end else tag = "R4";
    exp_gn1 = g1;
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(ts3), 1 << (NS-1-stg));
    chk(tag, int'(gn3), int'(exp_gn3));
    chk("R2", $countones(ts3), 1);
    if (gn3) chk("R6", int'(ts3[NS-1]), 1);
    chk("R7", int'(gn1), int'(exp_gn1));
    chk("R7", int'(ts1), 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit prev_gn;
    repeat (3) @(negedge clk);
    chk("R1", int'(ts3), 1 << (NS-1));
    chk("R1", int'(gn3), 0);
    chk("R8", $bits(ts1), 1);
    chk("R8", $bits(ts3), NS);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(ts3), 1 << (NS-1));
    chk("R1", int'(ts1), 1);

    // ordered sequence with idle gaps
    cyc(3'b001, 0); cyc(3'b000, 0); cyc(3'b010, 0); cyc(3'b000, 0);
    cyc(3'b100, 0); cyc(3'b000, 0);
    // out of order while idle
    cyc(3'b100, 0); cyc(3'b010, 0); cyc(3'b110, 0); cyc(3'b000, 0);
    // partial arm then wrong bits
    cyc(3'b001, 0); cyc(3'b001, 0); cyc(3'b100, 0); cyc(3'b101, 0);
    cyc(3'b010, 0); cyc(3'b011, 0); cyc(3'b001, 0); cyc(3'b100, 0);
    // all bits held high: advance each clock, fire every third
    for (int i = 0; i < 9; i++) cyc(3'b111, 0);
    cyc(3'b000, 0);
    // single-stage: pulse, gap, held
    cyc(3'b000, 1); cyc(3'b000, 0); cyc(3'b000, 1); cyc(3'b000, 1);
    cyc(3'b000, 1); cyc(3'b000, 0);

    // gn never high twice in a row on multi-step instance
    prev_gn = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(3'b111, 0);
      if (prev_gn) chk("R6", int'(gn3), 0);
      prev_gn = gn3;
    end
    cyc(3'b000, 0);

    // reset in mid-arm
    cyc(3'b001, 0); cyc(3'b010, 0);
    #1 rst_n = 1'b0;
    #2;
    chk("R1", int'(ts3), 1 << (NS-1));
    chk("R1", int'(gn3), 0);
    stg = 0;
    go3 = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(ts3), 1 << (NS-1));
    // final bit after reset must not fire
    cyc(3'b100, 0);
    cyc(3'b001, 0); cyc(3'b010, 0); cyc(3'b100, 0); cyc(3'b000, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule